// File: doc/BRIEF.md
# Solid Fill Blit Command Generator

This block turns one rectangle-fill request into the sequence of 32-bit command dwords that a 2D copy engine needs to paint that rectangle in a single colour. A request is a one-cycle `start` pulse that carries the rectangle corner and size, the colour, the surface stride in bytes, the surface height, a pixel-depth code, a tiling code, a destination address and a choice between two packet layouts. The block captures the whole request on the accepting edge, so the request inputs may change afterwards. It then streams the dwords out one per accepted beat. Running the commands is left to whatever consumes the stream.

The older layout is a short fill packet of 6 or 7 dwords. When the surface uses the Y or Tile4 arrangement, that packet is wrapped in two 8-dword blocks. The first block switches the engine's tile-mode control register to the needed arrangement, and the second switches it back to X. The newer layout is a fixed 16-dword packet that also carries the surface geometry.

The output is a valid/ready stream. The block drives `m_valid` high while it holds a dword. The dword moves on any rising edge where `m_ready` is also high. While `m_ready` is low, `m_data` and `m_last` stay frozen. `m_last` marks the final dword of the whole sequence, wrapper blocks included. `busy` is high from the accepting edge until the edge that takes the last dword. A `start` that arrives while `busy` is high is ignored.

Top module: `fill_blit_gen`

## Requirements
- R1: After reset, `m_valid`, `m_last`, `busy` and `err` are all low.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values. Each edge with `m_valid` and `m_ready` both high moves exactly one dword.
- R3: `m_last` is high only on the final dword of the sequence. After that dword is taken, `m_valid` and `busy` are low. A `start` pulse while `busy` is high changes nothing and raises no `err`. The total dword count is 6, 7, 22 or 23 for the older layout and 16 for the newer one.
- R4: Older-layout header is `0x54300000`, OR `0x800` when `tile_sel` is non-zero, OR a length field of 5 when `long_len`=1 and 4 when `long_len`=0.
- R5: The dword after the depth/pitch dword is `(y<<16)|x`. The next one is `((y+h)<<16)|(x+w)`, an exclusive end corner, with each half truncated to 16 bits.
- R6: In the older layout, the address follows the corners: the low 32 bits only when `long_len`=0, and low then high when `long_len`=1. The colour comes last.
- R7: Older-layout dword 1 is `depth|0x00F00000|pitch`. Depth is 0, `0x01000000` or `0x03000000` for `bpp_sel` 0 (8 bpp), 1 (16 bpp) or 2 (32 bpp). Pitch is stride/4 when `tile_sel`≠0 and the stride in bytes when `tile_sel`=0. The newer layout uses the same pitch rule.
- R8: With the older layout and `tile_sel` 2 (Y) or 3 (Tile4), the fill packet is wrapped. Before it comes `0x13000002, 0, 0, 0, 0x11000001, 0x00022200, 0x00030003, 0`. After it comes the same 8 dwords, with `0x00030000` in place of `0x00030003`.
- R9: The newer layout is exactly 16 dwords, in this order: header `0x5100000E|(d<<19)` with d = 0, 1, 2 for `bpp_sel` 0, 1, 2; then `(t<<30)|0x00400000|(pitch−1)` with t = 0, 1, 2 for `tile_sel` 0, 1, 3; then the two corners; then address low and high; then 0; then the colour; then five zeros; then the size dword; then two zeros.
- R10: The newer-layout size dword is `0x20000000|((pitch−1)<<14)|(surf_h−1)`.
- R11: `bpp_sel`=3, or `tile_sel`=2 with `fmt_new`=1, is rejected when `start` arrives with `busy` low. In that case `err` is high for one cycle right after the edge, and no dword is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse; sampled only while not busy |
| fmt_new | input | 1 | 0 selects the older layout, 1 selects the 16-dword layout |
| long_len | input | 1 | Older layout: 1 gives length field 5 and a two-dword address |
| tile_sel | input | 2 | 0 linear, 1 X, 2 Y, 3 Tile4 |
| bpp_sel | input | 2 | 0 = 8 bpp, 1 = 16 bpp, 2 = 32 bpp, 3 = invalid |
| rect_x | input | COORD_W | Left edge in pixels |
| rect_y | input | COORD_W | Top edge in rows |
| rect_w | input | COORD_W | Width in pixels |
| rect_h | input | COORD_W | Height in rows |
| stride | input | PITCH_W | Surface stride in bytes |
| surf_h | input | COORD_W | Surface height in rows |
| color | input | 32 | Fill colour |
| dst_addr | input | ADDR_W | Destination surface address |
| busy | output | 1 | A sequence is in progress |
| err | output | 1 | One-cycle reject pulse |
| m_valid | output | 1 | Stream dword available |
| m_ready | input | 1 | Consumer accepts the dword |
| m_data | output | 32 | Stream dword |
| m_last | output | 1 | Final dword of the sequence |

## Verification
The bench sweeps every combination of layout, tiling code, depth code and length select, 64 requests in all. For each request it computes the expected dword list arithmetically. The sweep separates the wrapped from the unwrapped older-layout packets, the one-dword from the two-dword address, the stride/4 pitch from the byte pitch, and each depth encoding. The rejected codes show that an error pulse replaces the stream. A repeating ready pattern stalls the stream at many different dword positions, which tests that the held dword stays frozen. A start pulse that would be rejected is sent in the middle of every accepted stream, which shows that a busy generator ignores new requests.

// File: rtl/fill_blit_pkg.sv
package fill_blit_pkg;

  // wrapper block dwords
  localparam logic [31:0] OP_FLUSH      = 32'h1300_0002;
  localparam logic [31:0] OP_LOAD_IMM   = 32'h1100_0001;
  localparam logic [31:0] TILE_CTL_REG  = 32'h0002_2200;
  localparam logic [31:0] TILE_CTL_ON   = 32'h0003_0003;
  localparam logic [31:0] TILE_CTL_OFF  = 32'h0003_0000;

  // older fill packet
  localparam logic [31:0] LEG_FILL_BASE = 32'h5430_0000;
  localparam logic [31:0] LEG_TILED     = 32'h0000_0800;
  localparam logic [31:0] LEG_ROP       = 32'h00F0_0000;

  // newer fill packet
  localparam logic [31:0] NEW_FILL_BASE = 32'h5100_000E;
  localparam logic [31:0] NEW_CACHE_SEL = 32'h0040_0000;
  localparam logic [31:0] NEW_SIZE_FLAG = 32'h2000_0000;

  localparam int WRAP_LEN = 8;
  localparam int NEW_LEN  = 16;

  typedef enum logic [1:0] {
    SEG_PRE  = 2'd0,
    SEG_FILL = 2'd1,
    SEG_POST = 2'd2
  } seg_e;

  typedef struct packed {
    logic [31:0] hdr;
    logic [31:0] dw1;
    logic [31:0] corner_a;
    logic [31:0] corner_b;
    logic [31:0] size_dw;
    logic [31:0] color;
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic        fmt_new;
    logic        addr_two;
    logic        wrap;
    logic [4:0]  fill_len;
  } fill_cfg_t;

endpackage

// File: rtl/fill_blit_decode.sv
module fill_blit_decode
  import fill_blit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 16,
  parameter int ADDR_W  = 48
) (
  input  logic               fmt_new,
  input  logic               long_len,
  input  logic [1:0]         tile_sel,
  input  logic [1:0]         bpp_sel,
  input  logic [COORD_W-1:0] rect_x,
  input  logic [COORD_W-1:0] rect_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [PITCH_W-1:0] stride,
  input  logic [COORD_W-1:0] surf_h,
  input  logic [31:0]        color,
  input  logic [ADDR_W-1:0]  dst_addr,
  output fill_cfg_t          cfg,
  output logic               ok
);

  logic               tiled;
  logic [PITCH_W-1:0] pitch;
  logic [PITCH_W-1:0] pitch_m1;
  logic [COORD_W:0]   end_x;
  logic [COORD_W:0]   end_y;
  logic [31:0]        leg_depth;
  logic [31:0]        new_depth;
  logic [1:0]         new_tcode;
  logic [31:0]        hi_part;

  generate
    if (ADDR_W > 32) begin : g_hi
      assign hi_part = 32'(dst_addr[ADDR_W-1:32]);
    end else begin : g_no_hi
      assign hi_part = '0;
    end
  endgenerate

  always_comb begin
    leg_depth = '0;
    new_depth = '0;
    case (bpp_sel)
      2'd1: begin leg_depth = 32'h0100_0000; new_depth = 32'h0008_0000; end
      2'd2: begin leg_depth = 32'h0300_0000; new_depth = 32'h0010_0000; end
      default: ;
    endcase
    case (tile_sel)
      2'd1:    new_tcode = 2'd1;
      2'd3:    new_tcode = 2'd2;
      default: new_tcode = 2'd0;
    endcase
  end

  assign tiled    = (tile_sel != 2'd0);
  assign pitch    = tiled ? (stride >> 2) : stride;
  assign pitch_m1 = pitch - 1'b1;
  assign end_x    = {1'b0, rect_x} + {1'b0, rect_w};
  assign end_y    = {1'b0, rect_y} + {1'b0, rect_h};
  assign ok       = (bpp_sel != 2'd3) && !(fmt_new && (tile_sel == 2'd2));

  always_comb begin
    cfg          = '0;
    cfg.fmt_new  = fmt_new;
    cfg.addr_two = fmt_new || long_len;
    cfg.wrap     = !fmt_new && tile_sel[1];
    cfg.fill_len = fmt_new ? 5'(NEW_LEN) : (long_len ? 5'd7 : 5'd6);
    if (fmt_new) begin
      cfg.hdr = NEW_FILL_BASE | new_depth;
      cfg.dw1 = {new_tcode, 30'b0} | NEW_CACHE_SEL | 32'(pitch_m1);
    end else begin
      cfg.hdr = LEG_FILL_BASE | (tiled ? LEG_TILED : 32'h0) | (long_len ? 32'd5 : 32'd4);
      cfg.dw1 = leg_depth | LEG_ROP | 32'(pitch);
    end
    cfg.corner_a = {16'(rect_y), 16'(rect_x)};
    cfg.corner_b = {16'(end_y), 16'(end_x)};
    cfg.size_dw  = NEW_SIZE_FLAG | (32'(pitch_m1) << 14) | 32'(surf_h - 1'b1);
    cfg.color    = color;
    cfg.addr_lo  = 32'(dst_addr);
    cfg.addr_hi  = hi_part;
  end

endmodule

// File: rtl/fill_blit_word.sv
module fill_blit_word
  import fill_blit_pkg::*;
(
  input  seg_e        seg,
  input  logic [4:0]  idx,
  input  fill_cfg_t   cfg,
  output logic [31:0] dword
);

  always_comb begin
    dword = '0;
    case (seg)
      SEG_PRE, SEG_POST: begin
        case (idx)
          5'd0:    dword = OP_FLUSH;
          5'd4:    dword = OP_LOAD_IMM;
          5'd5:    dword = TILE_CTL_REG;
          5'd6:    dword = (seg == SEG_PRE) ? TILE_CTL_ON : TILE_CTL_OFF;
          default: dword = '0;
        endcase
      end
      SEG_FILL: begin
        if (cfg.fmt_new) begin
          case (idx)
            5'd0:    dword = cfg.hdr;
            5'd1:    dword = cfg.dw1;
            5'd2:    dword = cfg.corner_a;
            5'd3:    dword = cfg.corner_b;
            5'd4:    dword = cfg.addr_lo;
            5'd5:    dword = cfg.addr_hi;
            5'd7:    dword = cfg.color;
            5'd13:   dword = cfg.size_dw;
            default: dword = '0;
          endcase
        end else begin
          case (idx)
            5'd0:    dword = cfg.hdr;
            5'd1:    dword = cfg.dw1;
            5'd2:    dword = cfg.corner_a;
            5'd3:    dword = cfg.corner_b;
            5'd4:    dword = cfg.addr_lo;
            5'd5:    dword = cfg.addr_two ? cfg.addr_hi : cfg.color;
            5'd6:    dword = cfg.color;
            default: dword = '0;
          endcase
        end
      end
      default: dword = '0;
    endcase
  end

endmodule

// File: rtl/fill_blit_seq.sv
module fill_blit_seq
  import fill_blit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       req_ok,
  input  fill_cfg_t  cfg_in,
  input  logic       m_ready,
  output logic       m_valid,
  output logic       m_last,
  output logic       busy,
  output logic       err,
  output seg_e       seg,
  output logic [4:0] idx,
  output fill_cfg_t  cfg_q
);

  logic       active;
  logic [4:0] seg_len;
  logic       at_end;
  logic       final_seg;
  logic       beat;

  assign seg_len   = (seg == SEG_FILL) ? cfg_q.fill_len : 5'(WRAP_LEN);
  assign at_end    = (idx == seg_len - 5'd1);
  assign final_seg = (seg == SEG_POST) || ((seg == SEG_FILL) && !cfg_q.wrap);
  assign m_valid   = active;
  assign busy      = active;
  assign m_last    = active && at_end && final_seg;
  assign beat      = active && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      err    <= 1'b0;
      seg    <= SEG_FILL;
      idx    <= '0;
      cfg_q  <= '0;
    end else begin
      err <= 1'b0;
      if (!active) begin
        if (start) begin
          if (req_ok) begin
            active <= 1'b1;
            cfg_q  <= cfg_in;
            seg    <= cfg_in.wrap ? SEG_PRE : SEG_FILL;
            idx    <= '0;
          end else begin
            err <= 1'b1;
          end
        end
      end else if (beat) begin
        if (at_end) begin
          idx <= '0;
          if (final_seg) begin
            active <= 1'b0;
          end else if (seg == SEG_PRE) begin
            seg <= SEG_FILL;
          end else begin
            seg <= SEG_POST;
          end
        end else begin
          idx <= idx + 5'd1;
        end
      end
    end
  end

  // independent beat count for the length check
  logic [5:0] beats;
  logic [5:0] exp_total;

  assign exp_total = (cfg_q.wrap ? 6'(2 * WRAP_LEN) : 6'd0) + 6'(cfg_q.fill_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats <= '0;
    end else if (m_valid && m_ready) begin
      beats <= m_last ? 6'd0 : beats + 6'd1;
    end
  end

  AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |-> (beats + 6'd1 == exp_total)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> (!m_valid && !busy)); // R3

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !m_valid); // R11

  AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(start)); // R11

endmodule

// File: rtl/fill_blit_gen.sv
module fill_blit_gen
  import fill_blit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 16,
  parameter int ADDR_W  = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               fmt_new,
  input  logic               long_len,
  input  logic [1:0]         tile_sel,
  input  logic [1:0]         bpp_sel,
  input  logic [COORD_W-1:0] rect_x,
  input  logic [COORD_W-1:0] rect_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [PITCH_W-1:0] stride,
  input  logic [COORD_W-1:0] surf_h,
  input  logic [31:0]        color,
  input  logic [ADDR_W-1:0]  dst_addr,
  output logic               busy,
  output logic               err,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [31:0]        m_data,
  output logic               m_last
);

  fill_cfg_t  cfg_in;
  fill_cfg_t  cfg_q;
  logic       req_ok;
  seg_e       seg;
  logic [4:0] idx;

  fill_blit_decode #(
    .COORD_W (COORD_W),
    .PITCH_W (PITCH_W),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .fmt_new  (fmt_new),
    .long_len (long_len),
    .tile_sel (tile_sel),
    .bpp_sel  (bpp_sel),
    .rect_x   (rect_x),
    .rect_y   (rect_y),
    .rect_w   (rect_w),
    .rect_h   (rect_h),
    .stride   (stride),
    .surf_h   (surf_h),
    .color    (color),
    .dst_addr (dst_addr),
    .cfg      (cfg_in),
    .ok       (req_ok)
  );

  fill_blit_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .req_ok  (req_ok),
    .cfg_in  (cfg_in),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_last  (m_last),
    .busy    (busy),
    .err     (err),
    .seg     (seg),
    .idx     (idx),
    .cfg_q   (cfg_q)
  );

  fill_blit_word u_word (
    .seg   (seg),
    .idx   (idx),
    .cfg   (cfg_q),
    .dword (m_data)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R2

endmodule

// File: tb/fill_blit_gen_bench.sv
module fill_blit_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        fmt_new;
  logic        long_len;
  logic [1:0]  tile_sel;
  logic [1:0]  bpp_sel;
  logic [15:0] rect_x, rect_y, rect_w, rect_h;
  logic [15:0] stride;
  logic [15:0] surf_h;
  logic [31:0] color;
  logic [47:0] dst_addr;
  logic        busy, err, m_valid, m_ready, m_last;
  logic [31:0] m_data;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_w [0:31];
  string       exp_t [0:31];
  int          exp_n;

  always #5 clk = ~clk;

  fill_blit_gen u_fill_blit_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt_new(fmt_new),
    .long_len(long_len), .tile_sel(tile_sel), .bpp_sel(bpp_sel),
    .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
    .stride(stride), .surf_h(surf_h), .color(color), .dst_addr(dst_addr),
    .busy(busy), .err(err), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last)
  );

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] w, input string tag);
    exp_w[exp_n] = w;
    exp_t[exp_n] = tag;
    exp_n++;
  endtask

  task automatic push_wrap(input logic [31:0] val);
    push(32'h1300_0002, "R8"); push(0, "R8"); push(0, "R8"); push(0, "R8");
    push(32'h1100_0001, "R8"); push(32'h0002_2200, "R8"); push(val, "R8"); push(0, "R8");
  endtask

  task automatic build();
    int pitch;
    logic [31:0] ca, cb;
    exp_n = 0;
    pitch = (tile_sel != 0) ? int'(stride) / 4 : int'(stride);
    ca = {rect_y, rect_x};
    cb = {16'(rect_y + rect_h), 16'(rect_x + rect_w)};
    if (!fmt_new) begin
      if (tile_sel >= 2) push_wrap(32'h0003_0003);
      push(32'h5430_0000 | ((tile_sel != 0) ? 32'h800 : 32'h0) | (long_len ? 32'd5 : 32'd4), "R4");
      push(((bpp_sel == 1) ? 32'h0100_0000 : (bpp_sel == 2) ? 32'h0300_0000 : 32'h0)
           | 32'h00F0_0000 | 32'(pitch), "R7");
      push(ca, "R5"); push(cb, "R5");
      push(dst_addr[31:0], "R6");
      if (long_len) push(32'(dst_addr[47:32]), "R6");
      push(color, "R6");
      if (tile_sel >= 2) push_wrap(32'h0003_0000);
    end else begin
      push(32'h5100_000E | (32'(bpp_sel) << 19), "R9");
      push((32'((tile_sel == 3) ? 2 : int'(tile_sel)) << 30) | 32'h0040_0000 | 32'(pitch - 1), "R9");
      push(ca, "R5"); push(cb, "R5");
      push(dst_addr[31:0], "R9"); push(32'(dst_addr[47:32]), "R9");
      push(0, "R9"); push(color, "R9");
      for (int i = 0; i < 5; i++) push(0, "R9");
      push(32'h2000_0000 | (32'(pitch - 1) << 14) | 32'(int'(surf_h) - 1), "R10");
      push(0, "R9"); push(0, "R9");
    end
  endtask

  task automatic run_case(input int seed);
    bit valid_req;
    int got, guard;
    bit prev_stall, injected;
    logic [31:0] prev_d;
    logic rdy;
    valid_req = (bpp_sel != 3) && !(fmt_new && tile_sel == 2);
    build();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!valid_req) begin
      chk(err == 1'b1, "R11", "reject pulse", 32'(err), 1);
      chk(m_valid == 1'b0, "R11", "no stream on reject", 32'(m_valid), 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!m_valid && !err, "R11", "quiet after reject", {30'b0, m_valid, err}, 0);
      end
      return;
    end
    chk(err == 1'b0, "R11", "no err on good request", 32'(err), 0);
    got = 0; guard = 0; prev_stall = 0; injected = 0; prev_d = '0;
    while (got < exp_n && guard < 300) begin
      start = 1'b0;
      if (injected) begin
        chk(err == 1'b0 && m_valid, "R3", "start while busy ignored", {30'b0, err, m_valid}, 1);
        injected = 0;
      end
      if (prev_stall)
        chk(m_valid && m_data == prev_d, "R2", "hold under stall", m_data, prev_d);
      rdy = ((guard + seed) % 4) != 2;
      m_ready = rdy;
      if (m_valid && rdy) begin
        chk(m_data == exp_w[got], exp_t[got], $sformatf("dword %0d", got), m_data, exp_w[got]);
        chk(m_last == (got == exp_n - 1), "R3", $sformatf("last flag at %0d", got),
            32'(m_last), 32'(got == exp_n - 1));
        got++;
        if (got == 4) begin
          start = 1'b1;
          bpp_sel = 2'd3;
          injected = 1;
        end
      end
      prev_stall = m_valid && !rdy;
      prev_d = m_data;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    m_ready = 1'b0;
    chk(got == exp_n, "R3", "dword count", 32'(got), 32'(exp_n));
    chk(!m_valid && !busy, "R3", "idle after last", {30'b0, m_valid, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; start = 1'b0; m_ready = 1'b0;
    fmt_new = 0; long_len = 0; tile_sel = 0; bpp_sel = 0;
    rect_x = 0; rect_y = 0; rect_w = 0; rect_h = 0;
    stride = 0; surf_h = 0; color = 0; dst_addr = 0;
    repeat (3) @(negedge clk);
    chk(!m_valid && !m_last && !busy && !err, "R1", "reset state",
        {28'b0, m_valid, m_last, busy, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && !busy && !err, "R1", "idle after reset", {29'b0, m_valid, busy, err}, 0);
    n = 0;
    for (int f = 0; f < 2; f++)
      for (int t = 0; t < 4; t++)
        for (int b = 0; b < 4; b++)
          for (int l = 0; l < 2; l++) begin
            fmt_new  = 1'(f);
            tile_sel = 2'(t);
            bpp_sel  = 2'(b);
            long_len = 1'(l);
            rect_x   = 16'(3 + 17 * t + b);
            rect_y   = 16'(7 + 40 * f + 9 * l);
            rect_w   = 16'(10 + 5 * b);
            rect_h   = 16'(4 + t);
            stride   = 16'(512 + 128 * t + 64 * l);
            surf_h   = 16'(32 + 8 * l);
            color    = 32'hA5C3_1E0F ^ (32'(n) * 32'h0101_0101);
            dst_addr = 48'hBEEF_1234_5670 + 48'(n) * 48'h1000;
            run_case(n);
            n++;
            @(negedge clk);
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule